// File: doc/BRIEF.md
# Processor Status Flag Register with Interrupt Gating

This block holds the 8-bit status byte of a small 8-bit processor core and decides when an external interrupt request is taken. The byte carries a two-bit page mode, a register-bank select, carry, zero and a global interrupt enable. Arithmetic results update carry and zero. Flag-logic instructions combine the whole byte with an 8-bit immediate through AND, OR or XOR. A return-from-interrupt reloads the byte from a value popped off the stack. The register can be read on the register bus. A bus write to it does nothing.

The interrupt request is only looked at on an instruction-boundary strobe, and only while the enable bit is set. When the request is taken, the block gives a one-cycle acknowledge pulse. It then offers the flag byte it held at that moment on a valid/ready push stream for the stack. The producer keeps `push_valid_o` high and `push_data_o` unchanged until `push_ready_i` is seen high. The enable bit is cleared on the clock edge where that transfer completes, and not earlier. No further request is taken while the push is still pending. The bank-select bit is also driven out as the ninth register-address bit.

Top module: `cpu_status_reg`

## Requirements
- R1: After reset the status byte is 00h, `push_valid_o` and `irq_ack_o` are 0, and `bank_o` is 0.
- R2: With `fop_valid_i` high, the byte becomes byte AND imm (code 0), byte OR imm (code 1), or byte XOR imm (code 2) on the next edge. Code 3 leaves the byte unchanged.
- R3: Bits 5 and 3 of the status byte always read 0, whatever a flag operation or a reload supplies.
- R4: The byte's bit layout is page mode [7:6], bank select [4], carry [2], zero [1] and enable [0]. With `alu_upd_i` high, carry and zero take `alu_carry_i` and `alu_zero_i`. If a flag operation is in the same cycle, the flag operation's result is used and the ALU values are dropped.
- R5: A read at offset F7h returns the byte with `rd_hit_o`=1 in either bank. Any other offset gives `rd_hit_o`=0 and `rd_data_o`=00h. A bus write to any offset leaves the byte unchanged.
- R6: `bank_o` equals status bit 4, and `reg_addr_o` is `{bank_o, rd_addr_i}`.
- R7: A request is taken only in a cycle with `step_i`=1, `irq_i`=1 and enable=1. With enable=0 or with no strobe, `irq_ack_o` stays 0.
- R8: One cycle after a request is taken, `irq_ack_o` pulses high for exactly one cycle and `push_valid_o` rises. `push_data_o` is the byte held in the cycle the request was taken, and it stays valid and stable until `push_ready_i` is high.
- R9: The enable bit stays set while the push is pending. It is cleared on the edge where `push_valid_o` and `push_ready_i` are both high. The other bits are unaffected by this.
- R10: With `reti_valid_i` high, the byte is reloaded from `reti_data_i` with bits 5 and 3 forced to 0. The reload takes priority over a flag operation and an ALU update in the same cycle.
- R11: While a push is pending, a further strobe with a request does not produce another acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| step_i | input | 1 | Instruction-boundary strobe |
| alu_upd_i | input | 1 | Load carry/zero from ALU |
| alu_carry_i | input | 1 | ALU carry result |
| alu_zero_i | input | 1 | ALU zero result |
| fop_valid_i | input | 1 | Flag-logic instruction executes |
| fop_code_i | input | 2 | 0 AND, 1 OR, 2 XOR, 3 none |
| fop_imm_i | input | 8 | Flag-logic immediate |
| reti_valid_i | input | 1 | Reload byte on interrupt return |
| reti_data_i | input | 8 | Popped status byte |
| irq_i | input | 1 | External interrupt request |
| irq_ack_o | output | 1 | One-cycle interrupt-taken pulse |
| push_valid_o | output | 1 | Status byte for the stack is valid |
| push_ready_i | input | 1 | Stack accepts the byte |
| push_data_o | output | 8 | Status byte to be stacked |
| rd_en_i | input | 1 | Register-bus read strobe |
| rd_addr_i | input | ADDR_W | Register-bus offset |
| rd_data_o | output | 8 | Read data |
| rd_hit_o | output | 1 | Read addressed this register |
| wr_en_i | input | 1 | Register-bus write strobe (no effect) |
| wr_addr_i | input | ADDR_W | Write offset (no effect) |
| wr_data_i | input | 8 | Write data (no effect) |
| bank_o | output | 1 | Register-bank select |
| reg_addr_o | output | ADDR_W+1 | Bank-extended register address |
| flags_o | output | 8 | Current status byte |

## Verification
The bench builds the block with its defaults: an 8-bit register offset and the status byte at offset F7h. With these defaults the full 512-location register space is addressed through `reg_addr_o`, and a hit at F7h can be compared across both banks. The push stream is held back for several cycles, which shows that the enable bit survives a stalled stack write and that the offered byte stays put. Flag-operation vectors include immediates with the reserved bits set and ALU updates that collide with flag operations.

// File: rtl/status_pkg.sv
package status_pkg;
  localparam int SW = 8;
  localparam int B_GIE   = 0;
  localparam int B_ZERO  = 1;
  localparam int B_CARRY = 2;
  localparam int B_BANK  = 4;
  localparam int B_PG_LO = 6;
  localparam int B_PG_HI = 7;
  localparam logic [SW-1:0] LIVE_MASK =
    (SW'(1) << B_GIE) | (SW'(1) << B_ZERO) | (SW'(1) << B_CARRY) |
    (SW'(1) << B_BANK) | (SW'(1) << B_PG_LO) | (SW'(1) << B_PG_HI);

  typedef enum logic [1:0] {
    FOP_AND = 2'd0,
    FOP_OR  = 2'd1,
    FOP_XOR = 2'd2,
    FOP_NOP = 2'd3
  } fop_e;
endpackage

// File: rtl/status_flag_core.sv
module status_flag_core
  import status_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alu_upd_i,
  input  logic          alu_carry_i,
  input  logic          alu_zero_i,
  input  logic          fop_valid_i,
  input  logic [1:0]    fop_code_i,
  input  logic [SW-1:0] fop_imm_i,
  input  logic          reti_valid_i,
  input  logic [SW-1:0] reti_data_i,
  input  logic          gie_clr_i,
  output logic [SW-1:0] flags_o
);
  logic [SW-1:0] flags_q;
  logic [SW-1:0] flags_d;
  logic [SW-1:0] fop_res;

  always_comb begin
    unique case (fop_e'(fop_code_i))
      FOP_AND: fop_res = flags_q & fop_imm_i;
      FOP_OR:  fop_res = flags_q | fop_imm_i;
      FOP_XOR: fop_res = flags_q ^ fop_imm_i;
      default: fop_res = flags_q;
    endcase
  end

  always_comb begin
    flags_d = flags_q;
    if (alu_upd_i) begin
      flags_d[B_CARRY] = alu_carry_i;
      flags_d[B_ZERO]  = alu_zero_i;
    end
    if (fop_valid_i) flags_d = fop_res;
    if (reti_valid_i) flags_d = reti_data_i;
    flags_d = flags_d & LIVE_MASK;
    if (gie_clr_i) flags_d[B_GIE] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/status_irq_gate.sv
module status_irq_gate
  import status_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_i,
  input  logic          irq_i,
  input  logic [SW-1:0] flags_i,
  input  logic          push_ready_i,
  output logic          push_valid_o,
  output logic [SW-1:0] push_data_o,
  output logic          ack_o,
  output logic          gie_clr_o
);
  logic          pend_q;
  logic          ack_q;
  logic [SW-1:0] save_q;
  logic          take;
  logic          done;

  assign take = step_i & irq_i & flags_i[B_GIE] & ~pend_q;
  assign done = pend_q & push_ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      ack_q  <= 1'b0;
      save_q <= '0;
    end else begin
      ack_q <= take;
      if (take) begin
        pend_q <= 1'b1;
        save_q <= flags_i;
      end else if (done) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign push_valid_o = pend_q;
  assign push_data_o  = save_q;
  assign ack_o        = ack_q;
  assign gie_clr_o    = done;
endmodule

// File: rtl/status_bus_port.sv
module status_bus_port
  import status_pkg::*;
#(
  parameter int              ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 8'hF7
) (
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [SW-1:0]     wr_data_i,
  input  logic [SW-1:0]     flags_i,
  output logic [SW-1:0]     rd_data_o,
  output logic              rd_hit_o,
  output logic [ADDR_W:0]   reg_addr_o
);
  logic hit;
  logic wr_unused;

  // Decode ignores the bank bit: the register answers in both banks.
  assign hit        = rd_en_i && (rd_addr_i == FLAG_ADDR);
  assign rd_hit_o   = hit;
  assign rd_data_o  = hit ? flags_i : '0;
  assign reg_addr_o = {flags_i[B_BANK], rd_addr_i};
  // Writes are deliberately dropped; the register is read-only on the bus.
  assign wr_unused  = ^{wr_en_i, wr_addr_i, wr_data_i};
endmodule

// File: rtl/cpu_status_reg.sv
module cpu_status_reg
  import status_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 8'hF7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  input  logic              alu_upd_i,
  input  logic              alu_carry_i,
  input  logic              alu_zero_i,
  input  logic              fop_valid_i,
  input  logic [1:0]        fop_code_i,
  input  logic [7:0]        fop_imm_i,
  input  logic              reti_valid_i,
  input  logic [7:0]        reti_data_i,
  input  logic              irq_i,
  output logic              irq_ack_o,
  output logic              push_valid_o,
  input  logic              push_ready_i,
  output logic [7:0]        push_data_o,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic              rd_hit_o,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  output logic              bank_o,
  output logic [ADDR_W:0]   reg_addr_o,
  output logic [7:0]        flags_o
);
  logic [SW-1:0] flags;
  logic          gie_clr;

  status_flag_core u_core (
    .clk          (clk),
    .rst_n        (rst_n),
    .alu_upd_i    (alu_upd_i),
    .alu_carry_i  (alu_carry_i),
    .alu_zero_i   (alu_zero_i),
    .fop_valid_i  (fop_valid_i),
    .fop_code_i   (fop_code_i),
    .fop_imm_i    (fop_imm_i),
    .reti_valid_i (reti_valid_i),
    .reti_data_i  (reti_data_i),
    .gie_clr_i    (gie_clr),
    .flags_o      (flags)
  );

  status_irq_gate u_gate (
    .clk          (clk),
    .rst_n        (rst_n),
    .step_i       (step_i),
    .irq_i        (irq_i),
    .flags_i      (flags),
    .push_ready_i (push_ready_i),
    .push_valid_o (push_valid_o),
    .push_data_o  (push_data_o),
    .ack_o        (irq_ack_o),
    .gie_clr_o    (gie_clr)
  );

  status_bus_port #(.ADDR_W(ADDR_W), .FLAG_ADDR(FLAG_ADDR)) u_bus (
    .rd_en_i    (rd_en_i),
    .rd_addr_i  (rd_addr_i),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .flags_i    (flags),
    .rd_data_o  (rd_data_o),
    .rd_hit_o   (rd_hit_o),
    .reg_addr_o (reg_addr_o)
  );

  assign bank_o  = flags[B_BANK];
  assign flags_o = flags;
endmodule

// File: rtl/status_reg_checker.sv
module status_reg_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       step_i,
  input logic       irq_i,
  input logic       alu_upd_i,
  input logic       fop_valid_i,
  input logic       reti_valid_i,
  input logic       wr_en_i,
  input logic       irq_ack_o,
  input logic       push_valid_o,
  input logic       push_ready_i,
  input logic [7:0] push_data_o,
  input logic [7:0] flags_o
);
  assert_rsvd_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_o[5] == 1'b0) && (flags_o[3] == 1'b0));

  assert_no_take_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && irq_i && !flags_o[0] && !push_valid_o) |=> !irq_ack_o);

  assert_ack_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack_o |=> !irq_ack_o);

  assert_push_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid_o && !push_ready_i) |=> (push_valid_o && $stable(push_data_o)));

  assert_gie_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid_o && push_ready_i) |=> !flags_o[0]);

  assert_gie_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid_o && !push_ready_i && flags_o[0] && !fop_valid_i && !reti_valid_i)
      |=> flags_o[0]);

  assert_write_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !alu_upd_i && !fop_valid_i && !reti_valid_i &&
     !(push_valid_o && push_ready_i)) |=> $stable(flags_o));

  assert_no_retake_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid_o && !$rose(push_valid_o)) |-> !irq_ack_o);
endmodule

bind cpu_status_reg status_reg_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .step_i       (step_i),
  .irq_i        (irq_i),
  .alu_upd_i    (alu_upd_i),
  .fop_valid_i  (fop_valid_i),
  .reti_valid_i (reti_valid_i),
  .wr_en_i      (wr_en_i),
  .irq_ack_o    (irq_ack_o),
  .push_valid_o (push_valid_o),
  .push_ready_i (push_ready_i),
  .push_data_o  (push_data_o),
  .flags_o      (flags_o)
);

// File: tb/cpu_status_reg_bench.sv
module cpu_status_reg_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       step_i = 0, alu_upd_i = 0, alu_carry_i = 0, alu_zero_i = 0;
  logic       fop_valid_i = 0;
  logic [1:0] fop_code_i = 0;
  logic [7:0] fop_imm_i = 0;
  logic       reti_valid_i = 0;
  logic [7:0] reti_data_i = 0;
  logic       irq_i = 0, push_ready_i = 0, rd_en_i = 0, wr_en_i = 0;
  logic [7:0] rd_addr_i = 0, wr_addr_i = 0, wr_data_i = 0;
  logic       irq_ack_o, push_valid_o, rd_hit_o, bank_o;
  logic [7:0] push_data_o, rd_data_o, flags_o;
  logic [8:0] reg_addr_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cpu_status_reg u_cpu_status_reg (
    .clk(clk), .rst_n(rst_n), .step_i(step_i),
    .alu_upd_i(alu_upd_i), .alu_carry_i(alu_carry_i), .alu_zero_i(alu_zero_i),
    .fop_valid_i(fop_valid_i), .fop_code_i(fop_code_i), .fop_imm_i(fop_imm_i),
    .reti_valid_i(reti_valid_i), .reti_data_i(reti_data_i),
    .irq_i(irq_i), .irq_ack_o(irq_ack_o),
    .push_valid_o(push_valid_o), .push_ready_i(push_ready_i), .push_data_o(push_data_o),
    .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .rd_hit_o(rd_hit_o),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .bank_o(bank_o), .reg_addr_o(reg_addr_o), .flags_o(flags_o)
  );

  // {code, imm, expected byte after the operation}, applied in order from 00h
  localparam logic [17:0] VEC [8] = '{
    {2'd1, 8'hFF, 8'hD7},
    {2'd0, 8'h0F, 8'h07},
    {2'd2, 8'h11, 8'h16},
    {2'd2, 8'h28, 8'h16},
    {2'd1, 8'hC0, 8'hD6},
    {2'd0, 8'h3F, 8'h16},
    {2'd3, 8'hFF, 8'h16},
    {2'd0, 8'h00, 8'h00}
  };

  task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic fop(input logic [1:0] c, input logic [7:0] imm);
    fop_valid_i = 1; fop_code_i = c; fop_imm_i = imm;
    cyc();
    fop_valid_i = 0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 flags", {1'b0, flags_o}, 9'h000);
    chk("R1 push_valid", {8'h0, push_valid_o}, 9'h0);
    chk("R1 ack", {8'h0, irq_ack_o}, 9'h0);
    chk("R1 bank", {8'h0, bank_o}, 9'h0);
    rst_n = 1;
    cyc();

    // R2 / R3 vector walk
    for (int i = 0; i < 8; i++) begin
      fop(VEC[i][17:16], VEC[i][15:8]);
      chk("R2 R3 flagop", {1'b0, flags_o}, {1'b0, VEC[i][7:0]});
    end

    // R4 ALU update, then collision with flag op
    alu_upd_i = 1; alu_carry_i = 1; alu_zero_i = 0;
    cyc();
    chk("R4 alu", {1'b0, flags_o}, 9'h004);
    alu_carry_i = 0; alu_zero_i = 1;
    fop(2'd1, 8'h01);
    alu_upd_i = 0;
    chk("R4 priority", {1'b0, flags_o}, 9'h005);
    fop(2'd0, 8'h00);

    // R10 reload wins over flag op
    reti_valid_i = 1; reti_data_i = 8'hFF;
    fop(2'd0, 8'h00);
    reti_valid_i = 0;
    chk("R10 reload", {1'b0, flags_o}, 9'h0D7);
    fop(2'd0, 8'h00);

    // R5 bus write ignored, read decode
    wr_en_i = 1; wr_addr_i = 8'hF7; wr_data_i = 8'hFF;
    cyc();
    wr_en_i = 0;
    chk("R5 write ignored", {1'b0, flags_o}, 9'h000);
    rd_en_i = 1; rd_addr_i = 8'hF6;
    #1;
    chk("R5 miss", {rd_hit_o, rd_data_o}, 9'h000);
    fop(2'd1, 8'h12);
    rd_addr_i = 8'hF7;
    #1;
    chk("R5 hit bank1", {rd_hit_o, rd_data_o}, 9'h112);
    chk("R6 bank addr", reg_addr_o, 9'h1F7);
    chk("R6 bank", {8'h0, bank_o}, 9'h001);
    rd_en_i = 0;
    fop(2'd0, 8'h00);

    // R7 enable off: request ignored
    irq_i = 1; step_i = 1;
    cyc();
    step_i = 0;
    chk("R7 off ignored", {irq_ack_o, push_valid_o}, 9'h000);
    // R7 enable on but no strobe
    fop(2'd1, 8'h05);
    cyc();
    chk("R7 no strobe", {irq_ack_o, push_valid_o}, 9'h000);

    // R8 take with strobe
    step_i = 1;
    cyc();
    step_i = 0;
    chk("R8 ack", {8'h0, irq_ack_o}, 9'h001);
    chk("R8 push", {push_valid_o, push_data_o}, 9'h105);
    fop(2'd1, 8'h40);
    chk("R8 ack single", {8'h0, irq_ack_o}, 9'h000);
    chk("R8 push stable", {push_valid_o, push_data_o}, 9'h105);
    chk("R9 gie kept", {1'b0, flags_o}, 9'h045);
    // R11 no retake while pending
    step_i = 1;
    cyc();
    step_i = 0;
    chk("R11 no retake", {8'h0, irq_ack_o}, 9'h000);
    push_ready_i = 1;
    cyc();
    push_ready_i = 0;
    chk("R9 gie cleared", {1'b0, flags_o}, 9'h044);
    chk("R8 push done", {8'h0, push_valid_o}, 9'h000);
    step_i = 1;
    cyc();
    step_i = 0; irq_i = 0;
    chk("R7 after clear", {8'h0, irq_ack_o}, 9'h000);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule